// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A start request clears the approximation register and opens the bit-clock window. The block then builds the output code one bit per clock, working down from the most significant bit. In each trial it presents a candidate code to an external DAC and reads back a one-bit comparator verdict. The DAC, the comparator and the reference sit outside the block.

A conversion cannot be interrupted once it is under way. The busy flag is high for the whole conversion. When the last bit has been settled, a one-cycle end-of-conversion pulse fires and busy falls. Only after that does a read request place the finished code on the data bus. When no read is in progress, the data enable is low and the bus is held at zero, which models the high-impedance state.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A start request while idle is accepted. In the next cycle busy is high and the trial code is all zeros.
- R2: One cycle after acceptance, the trial code has only bit W-1 set and the bit-clock enable is high.
- R3: In each trial cycle, the bit under test is kept if `cmp_keep_i` is 1 (the DAC output does not exceed the input) and cleared if it is 0. In the same step the next lower bit is set, so at most two bits of the trial code change per cycle.
- R4: The conversion performs exactly W trials. Busy is high for W+1 cycles. `eoc_o` pulses high for one cycle in the first cycle in which busy is low.
- R5: With an ideal DAC and comparator, the final code equals the input value exactly.
- R6: A start request while busy is ignored. The ongoing conversion continues unchanged.
- R7: A read request while busy, or in the same cycle as an accepted start, is refused: `data_oe_o` stays low. Whenever `data_oe_o` is low, `data_o` is zero.
- R8: A read while idle drives `data_oe_o` high and `data_o` with the held result in the next cycle. Repeated reads return the same code until the next accepted start.
- R9: Synchronous reset returns the block to idle: busy, bit-clock enable, eoc and data enable low, and trial code and result zero.
- R10: The bit-clock enable is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start request |
| cmp_keep_i | input | 1 | Comparator verdict: 1 when the DAC output does not exceed the input |
| read_i | input | 1 | Read request for the held result |
| trial_o | output | W | Candidate code driven to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| bit_clk_en_o | output | 1 | Bit-clock enable during the trial window |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| data_o | output | W | Result bus, zero when not enabled |
| data_oe_o | output | 1 | Result bus drive enable |

## Verification
The assertions assume that `cmp_keep_i` is a function of the current `trial_o` alone, as an ideal comparator against a steady input would be. The stimulus keeps this true by computing the verdict continuously from `trial_o` and a bench-held input value. That input value changes only while the block is idle, so it never moves in the middle of a search. The stimulus places start and read requests both inside and outside a conversion, so that the refusal paths are exercised as well as the normal ones.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_TRIAL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_ctrl_fsm.sv
module sar_ctrl_fsm
  import sar_conv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic last_bit_i,
  output logic clr_o,
  output logic seed_o,
  output logic step_o,
  output logic fin_o,
  output logic rd_allow_o,
  output logic busy_o,
  output logic bit_clk_en_o,
  output logic eoc_o
);
  seq_state_e state_q;

  assign clr_o      = (state_q == ST_IDLE) && start_i;
  assign seed_o     = (state_q == ST_SETUP);
  assign step_o     = (state_q == ST_TRIAL);
  assign fin_o      = step_o && last_bit_i;
  assign rd_allow_o = (state_q == ST_IDLE) && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      busy_o       <= 1'b0;
      bit_clk_en_o <= 1'b0;
      eoc_o        <= 1'b0;
    end else begin
      eoc_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SETUP;
            busy_o  <= 1'b1;
          end
        end
        ST_SETUP: begin
          state_q      <= ST_TRIAL;
          bit_clk_en_o <= 1'b1;
        end
        ST_TRIAL: begin
          if (last_bit_i) begin
            state_q      <= ST_IDLE;
            busy_o       <= 1'b0;
            bit_clk_en_o <= 1'b0;
            eoc_o        <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         seed_i,
  input  logic         step_i,
  input  logic         cmp_keep_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] decided_o,
  output logic         last_bit_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mask_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign decided_o[i] = mask_q[i] ? cmp_keep_i : trial_o[i];
  end

  assign last_bit_o = mask_q[0];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      trial_o <= '0;
      mask_q  <= '0;
    end else if (seed_i) begin
      trial_o <= TOP_BIT;
      mask_q  <= TOP_BIT;
    end else if (step_i) begin
      trial_o <= decided_o | (mask_q >> 1);
      mask_q  <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/sar_read_port.sv
module sar_read_port #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         fin_i,
  input  logic [W-1:0] decided_i,
  input  logic         read_i,
  input  logic         rd_allow_i,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic [W-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      result_q <= '0;
    end else if (fin_i) begin
      result_q <= decided_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else if (read_i && rd_allow_i) begin
      data_o    <= result_q;
      data_oe_o <= 1'b1;
    end else begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         cmp_keep_i,
  input  logic         read_i,
  output logic [W-1:0] trial_o,
  output logic         busy_o,
  output logic         bit_clk_en_o,
  output logic         eoc_o,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic         clr, seed, step, fin, rd_allow, last_bit;
  logic [W-1:0] decided;

  sar_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .last_bit_i   (last_bit),
    .clr_o        (clr),
    .seed_o       (seed),
    .step_o       (step),
    .fin_o        (fin),
    .rd_allow_o   (rd_allow),
    .busy_o       (busy_o),
    .bit_clk_en_o (bit_clk_en_o),
    .eoc_o        (eoc_o)
  );

  sar_approx_reg #(.W(W)) u_sar (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .seed_i     (seed),
    .step_i     (step),
    .cmp_keep_i (cmp_keep_i),
    .trial_o    (trial_o),
    .decided_o  (decided),
    .last_bit_o (last_bit)
  );

  sar_read_port #(.W(W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .fin_i      (fin),
    .decided_i  (decided),
    .read_i     (read_i),
    .rd_allow_i (rd_allow),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         read_i,
  input logic [W-1:0] trial_o,
  input logic         busy_o,
  input logic         bit_clk_en_o,
  input logic         eoc_o,
  input logic [W-1:0] data_o,
  input logic         data_oe_o
);
  p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && trial_o == '0));

  p_seed_msb_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_clk_en_o) |-> ($countones(trial_o) == 1 && trial_o[W-1]));

  p_step_small_r3: assert property (@(posedge clk) disable iff (rst)
    bit_clk_en_o |=> ($countones(trial_o ^ $past(trial_o)) <= 2));

  p_eoc_edge_r4: assert property (@(posedge clk) disable iff (rst)
    eoc_o |-> (!busy_o && $past(busy_o)));

  p_busy_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_clk_en_o && start_i) |=> (trial_o != '0));

  p_read_refused_r7: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !data_oe_o);

  p_bus_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> (data_o == '0));

  p_clk_gated_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bit_clk_en_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .read_i       (read_i),
  .trial_o      (trial_o),
  .busy_o       (busy_o),
  .bit_clk_en_o (bit_clk_en_o),
  .eoc_o        (eoc_o),
  .data_o       (data_o),
  .data_oe_o    (data_oe_o)
);

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         read_i = 1'b0;
  logic         cmp_keep_i;
  logic [W-1:0] trial_o, data_o;
  logic         busy_o, bit_clk_en_o, eoc_o, data_oe_o;
  logic [W-1:0] vin = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // ideal DAC plus comparator: keep when candidate does not exceed input
  assign cmp_keep_i = (trial_o <= vin);

  sar_conv_ctrl #(.W(W)) u_sar_conv_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .cmp_keep_i   (cmp_keep_i),
    .read_i       (read_i),
    .trial_o      (trial_o),
    .busy_o       (busy_o),
    .bit_clk_en_o (bit_clk_en_o),
    .eoc_o        (eoc_o),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_phase = 0;  // 0 idle, 1 setup, 2 trials
  int m_bit = 0;
  int m_trial = 0, m_result = 0, m_data = 0;
  bit m_busy = 0, m_clken = 0, m_eoc = 0, m_oe = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_trial = 0; m_result = 0; m_data = 0;
      m_busy = 0; m_clken = 0; m_eoc = 0; m_oe = 0;
    end else begin
      m_eoc = 0;
      if (m_phase == 0 && !start_i && read_i) begin
        m_oe = 1; m_data = m_result;
      end else begin
        m_oe = 0; m_data = 0;
      end
      case (m_phase)
        0: if (start_i) begin
             m_phase = 1; m_busy = 1; m_trial = 0; m_result = 0;
           end
        1: begin
             m_phase = 2; m_clken = 1; m_bit = W - 1; m_trial = 1 << (W - 1);
           end
        default: begin
          if (!(m_trial <= int'(vin))) m_trial = m_trial & ~(1 << m_bit);
          if (m_bit == 0) begin
            m_result = m_trial; m_phase = 0; m_busy = 0; m_clken = 0; m_eoc = 1;
          end else begin
            m_bit = m_bit - 1;
            m_trial = m_trial | (1 << m_bit);
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy_o == m_busy, "R4 busy", busy_o, m_busy);
      check(eoc_o == m_eoc, "R4 eoc", eoc_o, m_eoc);
      check(bit_clk_en_o == m_clken, "R10 clken", bit_clk_en_o, m_clken);
      check(int'(trial_o) == m_trial, "R3 trial", trial_o, m_trial);
      check(data_oe_o == m_oe, "R7 oe", data_oe_o, m_oe);
      check(int'(data_o) == m_data, "R8 data", data_o, m_data);
    end
  end

  task automatic convert(input logic [W-1:0] value, input bit poke);
    int cycles;
    vin = value;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o && trial_o == '0, "R1 accept", trial_o, 0);
    cycles = 1;
    @(negedge clk);
    check(trial_o == 12'h800 && bit_clk_en_o, "R2 seed", trial_o, 12'h800);
    cycles++;
    while (busy_o && cycles < 40) begin
      if (poke && cycles == 5) begin start_i = 1'b1; read_i = 1'b1; end
      @(negedge clk);
      cycles++;
      if (poke && cycles == 6) begin
        start_i = 1'b0; read_i = 1'b0;
        check(!data_oe_o && data_o == '0, "R7 refused", data_oe_o, 0);
      end
    end
    check(cycles == W + 2, "R4 length", cycles - 1, W + 1);
    check(eoc_o, "R4 eoc pulse", eoc_o, 1);
    read_i = 1'b1;
    @(negedge clk);
    check(data_oe_o && data_o == value, poke ? "R6 ignored start" : "R5 result", data_o, value);
    @(negedge clk);
    check(data_oe_o && data_o == value, "R8 repeat", data_o, value);
    read_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !bit_clk_en_o && !eoc_o && !data_oe_o && trial_o == '0,
          "R9 reset", busy_o, 0);
    rst = 1'b0;
    read_i = 1'b1;
    @(negedge clk);
    check(data_oe_o && data_o == '0, "R8 read idle", data_o, 0);
    read_i = 1'b0;
    // read and start together: read refused
    @(negedge clk); start_i = 1'b1; read_i = 1'b1; vin = 12'h3C3;
    @(negedge clk); start_i = 1'b0; read_i = 1'b0;
    check(!data_oe_o, "R7 start+read", data_oe_o, 0);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    convert(12'h000, 1'b0);
    convert(12'hFFF, 1'b0);
    convert(12'h800, 1'b0);
    convert(12'h7FF, 1'b1);
    convert(12'hA5A, 1'b1);
    convert(12'h001, 1'b0);
    convert(12'h123, 1'b0);
    // reset mid-conversion
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy_o && !bit_clk_en_o && trial_o == '0 && !data_oe_o, "R9 mid reset", trial_o, 0);
    rst = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule